// File: doc/BRIEF.md
# Macro-Op Loop Sequencer

This block sits behind a simple in-order decoder. Software can record a short group of register operations, plus an optional counted loop branch, into one of a few numbered macro slots. It can then invoke the slot as a single instruction. While a definition is open, every incoming operation is stored and not executed. On invocation, all stored operations issue together in one cycle against an 8-entry register file. All sources are read before any result is written, so `r0=r0+r1` together with `r1=r0+r7` gives a parallel assignment.

A recorded loop branch adds one to its counter register and compares the new value with a limit register. If the two differ, the macro runs again in the next cycle. It does not branch to an address. A scoreboard input marks registers whose values are still pending, and issue simply waits on them. A serial stream port saves the macro slots for a context switch and loads them back.

The instruction input is valid/ready. A word transfers on a rising edge where both are high. The sender holds `in_word` stable while `in_valid` is high and `in_ready` is low. `in_ready` may depend on `in_word`, because the scoreboard check looks at its register fields. The save stream holds `so_data` while `so_valid` is high and `so_ready` is low. The restore stream takes a word on each edge where `si_valid` and `si_ready` are both high.

Top module: `macro_seq`

## Requirements
- R1: After reset all registers read 0, every slot is empty, `in_ready` is 1, `so_valid` is 0 and `def_err` is 0.
- R2: The instruction word is laid out as follows. Bits [15:13] hold the kind: 0 add, 1 subtract, 2 xor, 3 load-immediate, 4 begin, 5 end, 6 loop, 7 invoke. Bits [12:10] hold rd, [9:7] hold ra and [6:4] hold rb. Load-immediate takes an unsigned 7-bit value from [6:0]. Begin and invoke take the slot from [0]. Outside a definition, an add, subtract, xor or load-immediate writes rd on its accepting edge, and the new value appears on `rd_data` after that edge.
- R3: Between an accepted begin and its end, operations are recorded only, and the register file does not change.
- R4: An invoke of a valid slot runs all of its recorded operations on one edge. Every source is read before any destination is written.
- R5: A recorded loop (counter = ra field, limit = rb field) writes counter+1 on each run. The macro runs again while the new counter differs from the limit, and `in_ready` stays low while it repeats. Starting from counter c and limit l, with l > c, the macro runs l−c times.
- R6: A definition is rejected in these cases: two operations write the same register, more than 4 operations are given, an operation writes the loop counter, a second loop appears, an operation follows the loop, or a begin or invoke appears inside the definition. On rejection `def_err` is high for the one cycle after the end, and the slot is left empty.
- R7: When `reg_busy` has a bit set for any register named in the rd, ra or rb field of the pending direct operation, or of a valid invoked or repeating macro (including the loop's counter and limit), issue waits. `in_ready` is low and no register changes.
- R8: A one-cycle `save_go` while idle streams the save image out, one word per transfer, honouring `so_ready`. The image is 10 words: slot 0's header and its four operation words, then the same for slot 1. The header has [15] valid, [14] loop, [13:11] operation count, [5:3] counter and [2:0] limit. An operation word is the instruction word with bit 15 cleared, and unused operation words are 0.
- R9: Ten words accepted on the restore stream overwrite the slots in the same order. Afterwards the slots behave as the saved ones did.
- R10: Invoking an empty or rejected slot, an end outside a definition, or a loop outside a definition consumes the word with no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Instruction word accepted this edge if valid |
| in_word | input | 16 | Decoded instruction word |
| reg_busy | input | 8 | Scoreboard: register value not yet available |
| rd_addr | input | 3 | Register read-port address |
| rd_data | output | 32 | Register read-port data |
| def_err | output | 1 | One-cycle pulse: definition rejected |
| save_go | input | 1 | Start streaming the save image |
| so_valid | output | 1 | Save word valid |
| so_ready | input | 1 | Save word taken |
| so_data | output | 16 | Save word |
| si_valid | input | 1 | Restore word valid |
| si_ready | output | 1 | Restore word accepted this edge if valid |
| si_data | input | 16 | Restore word |

## Verification
The checks assume that `in_word` stays stable while a word waits for acceptance. They also assume that a restore image is one the block itself produced, and that a loop's limit is reachable from the counter's value when the macro is invoked. The stimulus changes inputs only on falling edges and holds each instruction until `in_ready` is seen high. It sets every loop counter below its limit before invoking. It restores exactly the 10 words it saved earlier, and raises `save_go` only while no macro repeats and no definition is open.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int WORD_W = 16;
  localparam int RA_W   = 3;

  typedef enum logic [2:0] {
    K_ADD   = 3'd0,
    K_SUB   = 3'd1,
    K_XOR   = 3'd2,
    K_LDI   = 3'd3,
    K_BEGIN = 3'd4,
    K_END   = 3'd5,
    K_LOOP  = 3'd6,
    K_CALL  = 3'd7
  } kind_e;
endpackage

// File: rtl/mseq_alu.sv
module mseq_alu #(
  parameter int DW = 32
) (
  input  logic [1:0]    fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [6:0]    imm,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (fn)
      2'd0:    y = a + b;
      2'd1:    y = a - b;
      2'd2:    y = a ^ b;
      default: y = DW'(imm);
    endcase
  end
endmodule

// File: rtl/mseq_regfile.sv
module mseq_regfile import mseq_pkg::*; #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int NWP  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWP-1:0]            we,
  input  logic [NWP-1:0][RA_W-1:0]  wa,
  input  logic [NWP-1:0][DW-1:0]    wd,
  output logic [NREG-1:0][DW-1:0]   q
);
  // later ports win; the loop port is last
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int p = 0; p < NWP; p++) begin
        if (we[p]) q[wa[p]] <= wd[p];
      end
    end
  end
endmodule

// File: rtl/mseq_store.sv
module mseq_store import mseq_pkg::*; #(
  parameter int NSLOT = 2,
  parameter int NOPS  = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      acc,
  input  logic [WORD_W-1:0]                         instr,
  input  logic                                      run_busy,
  input  logic                                      save_go,
  input  logic                                      so_ready,
  input  logic                                      si_valid,
  input  logic [WORD_W-1:0]                         si_data,
  output logic                                      defining,
  output logic [NSLOT*(NOPS+1)-1:0][WORD_W-1:0]     words,
  output logic                                      def_err,
  output logic                                      so_valid,
  output logic [WORD_W-1:0]                         so_data,
  output logic                                      si_ready,
  output logic                                      si_busy,
  output logic                                      saving
);
  localparam int WPS = NOPS + 1;
  localparam int NW  = NSLOT * WPS;
  localparam int PW  = (NW > 1) ? $clog2(NW) : 1;
  localparam int SLW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  kind_e           kind;
  logic [SLW-1:0]  dslot;
  logic [2:0]      cnt;
  logic [7:0]      wmask;
  logic            loop_seen, bad;
  logic [2:0]      lctr, llim;
  logic [PW-1:0]   sptr, rptr;
  logic            start_save;

  assign kind       = kind_e'(instr[15:13]);
  assign start_save = save_go && !saving && !defining && !run_busy && !si_busy;
  assign si_ready   = !saving && !defining && !save_go && !run_busy;
  assign si_busy    = (rptr != '0);
  assign so_valid   = saving;
  assign so_data    = words[sptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words     <= '0;
      defining  <= 1'b0;
      dslot     <= '0;
      cnt       <= '0;
      wmask     <= '0;
      loop_seen <= 1'b0;
      bad       <= 1'b0;
      lctr      <= '0;
      llim      <= '0;
      def_err   <= 1'b0;
      saving    <= 1'b0;
      sptr      <= '0;
      rptr      <= '0;
    end else begin
      def_err <= 1'b0;
      if (acc && !defining && kind == K_BEGIN) begin
        defining  <= 1'b1;
        dslot     <= instr[SLW-1:0];
        cnt       <= '0;
        wmask     <= '0;
        loop_seen <= 1'b0;
        bad       <= 1'b0;
        lctr      <= '0;
        llim      <= '0;
        for (int w = 0; w < WPS; w++)
          words[PW'(int'(instr[SLW-1:0]) * WPS + w)] <= '0;
      end else if (acc && defining) begin
        unique case (kind)
          K_ADD, K_SUB, K_XOR, K_LDI: begin
            if (int'(cnt) == NOPS || loop_seen || wmask[instr[12:10]]) begin
              bad <= 1'b1;
            end else begin
              words[PW'(int'(dslot) * WPS + 1 + int'(cnt))] <= {1'b0, instr[14:0]};
              cnt <= cnt + 3'd1;
              wmask[instr[12:10]] <= 1'b1;
            end
          end
          K_LOOP: begin
            if (loop_seen || wmask[instr[9:7]]) begin
              bad <= 1'b1;
            end else begin
              loop_seen <= 1'b1;
              lctr      <= instr[9:7];
              llim      <= instr[6:4];
            end
          end
          K_END: begin
            words[PW'(int'(dslot) * WPS)] <= {!bad, loop_seen, cnt, 5'b0, lctr, llim};
            defining <= 1'b0;
            def_err  <= bad;
          end
          default: bad <= 1'b1;
        endcase
      end
      if (start_save) begin
        saving <= 1'b1;
        sptr   <= '0;
      end else if (saving && so_ready) begin
        if (int'(sptr) == NW - 1) saving <= 1'b0;
        else sptr <= sptr + 1'b1;
      end
      if (si_valid && si_ready) begin
        words[rptr] <= si_data;
        rptr <= (int'(rptr) == NW - 1) ? '0 : rptr + 1'b1;
      end
    end
  end

  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid && !so_ready |=> so_valid && $stable(so_data)); // R8
  AST_ERR_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    def_err |-> $past(acc && defining && kind == K_END)); // R6
endmodule

// File: rtl/macro_seq.sv
module macro_seq import mseq_pkg::*; #(
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int NSLOT = 2,
  parameter int NOPS  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  input  logic [NREG-1:0]     reg_busy,
  input  logic [RA_W-1:0]     rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic                def_err,
  input  logic                save_go,
  output logic                so_valid,
  input  logic                so_ready,
  output logic [WORD_W-1:0]   so_data,
  input  logic                si_valid,
  output logic                si_ready,
  input  logic [WORD_W-1:0]   si_data
);
  localparam int WPS = NOPS + 1;
  localparam int NW  = NSLOT * WPS;
  localparam int NWP = NOPS + 1;
  localparam int PW  = (NW > 1) ? $clog2(NW) : 1;
  localparam int SLW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [NREG-1:0][DW-1:0]     rf_q;
  logic [NW-1:0][WORD_W-1:0]   words;
  logic                        defining, saving, si_busy;
  logic                        running;
  logic [SLW-1:0]              run_slot, src;
  kind_e                       kind;
  logic                        is_alu, is_call;
  logic                        m_valid, m_loop;
  logic [2:0]                  m_cnt, m_ctr, m_lim;
  logic [NREG-1:0]             mmask, dmask, need;
  logic                        stall, acc, exec_macro, exec_direct, again;
  logic [NWP-1:0]              we;
  logic [NWP-1:0][RA_W-1:0]    wa;
  logic [NWP-1:0][DW-1:0]      wd;

  assign kind    = kind_e'(in_word[15:13]);
  assign is_alu  = !in_word[15];
  assign is_call = (kind == K_CALL);
  assign src     = running ? run_slot : in_word[SLW-1:0];

  assign m_valid = words[PW'(int'(src) * WPS)][15];
  assign m_loop  = words[PW'(int'(src) * WPS)][14];
  assign m_cnt   = words[PW'(int'(src) * WPS)][13:11];
  assign m_ctr   = words[PW'(int'(src) * WPS)][5:3];
  assign m_lim   = words[PW'(int'(src) * WPS)][2:0];

  // scoreboard masks for the direct op and for the selected macro
  always_comb begin
    mmask = '0;
    for (int i = 0; i < NOPS; i++) begin
      if (int'(m_cnt) > i) begin
        mmask[words[PW'(int'(src) * WPS + 1 + i)][12:10]] = 1'b1;
        mmask[words[PW'(int'(src) * WPS + 1 + i)][9:7]]   = 1'b1;
        mmask[words[PW'(int'(src) * WPS + 1 + i)][6:4]]   = 1'b1;
      end
    end
    if (m_loop) begin
      mmask[m_ctr] = 1'b1;
      mmask[m_lim] = 1'b1;
    end
    dmask = '0;
    dmask[in_word[12:10]] = 1'b1;
    dmask[in_word[9:7]]   = 1'b1;
    dmask[in_word[6:4]]   = 1'b1;
    if (running)                            need = mmask;
    else if (!defining && is_alu)           need = dmask;
    else if (!defining && is_call && m_valid) need = mmask;
    else                                    need = '0;
  end

  assign stall       = |(need & reg_busy);
  assign in_ready    = !running && !saving && !save_go && !si_busy && !si_valid && !stall;
  assign acc         = in_valid && in_ready;
  assign exec_direct = acc && !defining && is_alu;
  assign exec_macro  = running ? !stall : (acc && !defining && is_call && m_valid);
  assign again       = m_loop && ((rf_q[m_ctr] + DW'(1)) != rf_q[m_lim]);

  for (genvar i = 0; i < NOPS; i++) begin : g_lane
    logic [WORD_W-1:0] opw;
    logic [DW-1:0]     y;
    assign opw = (i == 0 && exec_direct) ? in_word : words[PW'(int'(src) * WPS + 1 + i)];
    mseq_alu #(.DW(DW)) u_alu (
      .fn (opw[14:13]),
      .a  (rf_q[opw[9:7]]),
      .b  (rf_q[opw[6:4]]),
      .imm(opw[6:0]),
      .y  (y)
    );
    assign we[i] = (exec_macro && int'(m_cnt) > i) || (i == 0 && exec_direct);
    assign wa[i] = opw[12:10];
    assign wd[i] = y;
  end

  assign we[NOPS] = exec_macro && m_loop;
  assign wa[NOPS] = m_ctr;
  assign wd[NOPS] = rf_q[m_ctr] + DW'(1);

  mseq_regfile #(.NREG(NREG), .DW(DW), .NWP(NWP)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .wa(wa), .wd(wd), .q(rf_q)
  );

  mseq_store #(.NSLOT(NSLOT), .NOPS(NOPS)) u_store (
    .clk(clk), .rst_n(rst_n), .acc(acc), .instr(in_word), .run_busy(running),
    .save_go(save_go), .so_ready(so_ready), .si_valid(si_valid), .si_data(si_data),
    .defining(defining), .words(words), .def_err(def_err), .so_valid(so_valid),
    .so_data(so_data), .si_ready(si_ready), .si_busy(si_busy), .saving(saving)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      run_slot <= '0;
    end else if (exec_macro) begin
      running  <= again;
      run_slot <= src;
    end
  end

  assign rd_data = rf_q[rd_addr];

  AST_LOOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    running && !stall |=> rf_q[$past(m_ctr)] == $past(rf_q[m_ctr]) + DW'(1)); // R5
  AST_DEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    defining && acc |=> $stable(rf_q)); // R3
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && stall && !running |=> $stable(rf_q)); // R7
endmodule

// File: tb/macro_seq_tb.sv
module macro_seq_tb;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready;
  logic [15:0] in_word = '0;
  logic [7:0]  reg_busy = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        def_err, save_go = 0, so_valid, so_ready = 0, si_valid = 0, si_ready;
  logic [15:0] so_data, si_data = '0;
  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] img [10];

  always #(PERIOD/2) clk = ~clk;

  macro_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .reg_busy(reg_busy), .rd_addr(rd_addr), .rd_data(rd_data), .def_err(def_err),
    .save_go(save_go), .so_valid(so_valid), .so_ready(so_ready), .so_data(so_data),
    .si_valid(si_valid), .si_ready(si_ready), .si_data(si_data)
  );

  function automatic logic [15:0] alu(int k, int rd, int ra, int rb);
    return {k[2:0], rd[2:0], ra[2:0], rb[2:0], 4'b0};
  endfunction
  function automatic logic [15:0] ldi(int rd, int imm);
    return {3'd3, rd[2:0], 3'b0, imm[6:0]};
  endfunction
  function automatic logic [15:0] ctl(int k, int slot);
    return {k[2:0], 12'b0, slot[0]};
  endfunction

  // {instruction, register to read back, expected value}
  localparam logic [50:0] VEC [10] = '{
    {ldi(1, 5),        3'd1, 32'd5},
    {ldi(2, 9),        3'd2, 32'd9},
    {alu(0, 3, 1, 2),  3'd3, 32'd14},
    {alu(1, 4, 1, 2),  3'd4, 32'hFFFF_FFFC},
    {alu(2, 5, 3, 2),  3'd5, 32'd7},
    {alu(0, 3, 3, 3),  3'd3, 32'd28},
    {ldi(6, 127),      3'd6, 32'd127},
    {alu(1, 6, 6, 1),  3'd6, 32'd122},
    {alu(2, 5, 5, 5),  3'd5, 32'd0},
    {alu(0, 4, 4, 6),  3'd4, 32'd118}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic rreg(int r, output logic [31:0] v);
    rd_addr = r[2:0];
    #1 v = rd_data;
  endtask

  task automatic issue(logic [15:0] w);
    in_valid = 1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a0, a1;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_ready", in_ready, 1);
    chk("R1 so_valid", so_valid, 0);
    chk("R1 def_err", def_err, 0);
    rreg(3, v); chk("R1 reg3", v, 0);

    // R2 table of direct operations
    for (int i = 0; i < 10; i++) begin
      issue(VEC[i][50:35]);
      rreg(int'(VEC[i][34:32]), v);
      chk("R2 direct op", v, VEC[i][31:0]);
    end

    // R10 empty slot, stray end and loop
    issue(ctl(7, 0)); issue(ctl(5, 0)); issue(alu(6, 0, 1, 2));
    rreg(1, v); chk("R10 empty invoke", v, 5);
    rreg(0, v); chk("R10 stray loop", v, 0);

    // R3 recording does not execute
    issue(ldi(0, 3)); issue(ldi(1, 4));
    issue(ctl(4, 0)); issue(alu(0, 0, 0, 1)); issue(alu(0, 1, 0, 7));
    rreg(0, v); chk("R3 not executed", v, 3);
    issue(ctl(5, 0));
    chk("R6 clean end no error", def_err, 0);
    // R4 parallel assignment
    issue(ctl(7, 0));
    rreg(0, v); chk("R4 r0", v, 7);
    rreg(1, v); chk("R4 r1 old r0", v, 3);
    issue(ctl(7, 0));
    rreg(0, v); chk("R4 r0 second", v, 10);
    rreg(1, v); chk("R4 r1 second", v, 7);

    // R5 counted loop
    issue(ldi(2, 0)); issue(ldi(3, 5)); issue(ldi(4, 2)); issue(ldi(5, 0));
    issue(ctl(4, 1)); issue(alu(0, 5, 5, 4)); issue(alu(6, 0, 2, 3)); issue(ctl(5, 1));
    issue(ctl(7, 1));
    n = 0;
    while (!in_ready) begin n++; @(negedge clk); end
    chk("R5 repeat cycles", n, 4);
    rreg(5, v); chk("R5 accumulated", v, 10);
    rreg(2, v); chk("R5 counter", v, 5);

    // R7 operand stall
    reg_busy = 8'h02;
    in_valid = 1; in_word = alu(0, 6, 1, 2);
    repeat (3) begin
      @(negedge clk);
      chk("R7 ready low", in_ready, 0);
    end
    rreg(6, v); chk("R7 no write", v, 122);
    reg_busy = 8'h00;
    @(negedge clk); in_valid = 0;
    rreg(6, v); chk("R7 after release", v, 12);

    // R8 save with back-pressure
    save_go = 1; @(negedge clk); save_go = 0;
    n = 0;
    for (int c = 0; c < 60 && n < 10; c++) begin
      so_ready = c[0];
      if (so_valid && so_ready) begin img[n] = so_data; n++; end
      @(negedge clk);
    end
    so_ready = 0;
    chk("R8 word count", n, 10);
    chk("R8 done", so_valid, 0);
    chk("R8 hdr0", img[0], 16'h9000);
    chk("R8 op0a", img[1], alu(0, 0, 0, 1) & 16'h7FFF);
    chk("R8 op0b", img[2], alu(0, 1, 0, 7));
    chk("R8 op0c", img[3], 0);
    chk("R8 hdr1", img[5], 16'hC813);
    chk("R8 op1a", img[6], alu(0, 5, 5, 4));
    chk("R8 op1b", img[7], 0);

    // R6 rejected definitions
    issue(ctl(4, 0)); issue(alu(0, 0, 0, 1)); issue(alu(1, 0, 2, 3)); issue(ctl(5, 0));
    chk("R6 dup dest flag", def_err, 1);
    @(negedge clk);
    chk("R6 flag one cycle", def_err, 0);
    rreg(0, a0);
    issue(ctl(7, 0));
    rreg(0, v); chk("R6 rejected slot empty", v, a0);
    issue(ctl(4, 1)); issue(alu(0, 2, 2, 4)); issue(alu(6, 0, 2, 3)); issue(ctl(5, 1));
    chk("R6 counter written flag", def_err, 1);
    rreg(5, a1);
    issue(ctl(7, 1));
    rreg(5, v); chk("R6 rejected loop slot", v, a1);

    // R9 restore
    for (int i = 0; i < 10; i++) begin
      si_valid = 1; si_data = img[i];
      while (!si_ready) @(negedge clk);
      @(negedge clk);
    end
    si_valid = 0;
    rreg(0, a0); rreg(1, a1);
    issue(ctl(7, 0));
    rreg(0, v); chk("R9 slot0 r0", v, a0 + a1);
    rreg(1, v); chk("R9 slot0 r1", v, a0);
    issue(ldi(2, 3));
    rreg(5, a1);
    issue(ctl(7, 1));
    while (!in_ready) @(negedge clk);
    rreg(5, v); chk("R9 slot1 loop", v, a1 + 4);
    rreg(2, v); chk("R9 slot1 counter", v, 5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule